// File: doc/BRIEF.md
# Data Bus Turnaround Gap Enforcer

This block sits where a multi-rank DRAM controller issues its commands. It decides whether the next data-bus transaction, called the candidate, may go out yet. The decision depends on the direction (read or write) and the rank of the last transaction that was issued. For each kind of transition the required number of idle controller cycles is a base gap plus a separately programmed extra gap. The base gap is worked out elsewhere from the memory timing. The extra gap lets board-specific bus contention be absorbed without touching that derivation.

The controller presents the candidate's direction and rank every cycle and reads `issueOk`. It pulses `issueStb` in the cycle it issues. An issue that is accepted becomes the new reference transaction and restarts the count of elapsed cycles. The candidate may change while it waits, and the permission is then re-evaluated against the cycles already elapsed.

Transition kind index k, which selects the base entry `baseGap[k]`:
- 0: same rank, same direction.
- 1: same rank, read then write.
- 2: same rank, write then read.
- 3: different rank, read then read.
- 4: different rank, read then write.
- 5: different rank, write then write.
- 6: different rank, write then read.

For k from 1 to 6 the extra entry is `extraGap[k-1]`. A direction of 1 means write and 0 means read.

Top module: `tgap_top`

## Requirements
- R1: After reset, `issueOk` is 1 for every candidate direction and rank until the first accepted issue.
- R2: An issue is accepted only on a clock edge where `issueStb` and `issueOk` are both 1. A strobe while `issueOk` is 0 is ignored: the reference transaction and the elapsed count stay unchanged, so the permission later rises in the same cycle it would have without the strobe.
- R3: After an accepted issue, `issueOk` is 0 for exactly G controller cycles and 1 in cycle G+1, where G is the required gap of the current candidate. G=0 permits back-to-back issue.
- R4: For same rank and same direction (kind 0), G equals `baseGap[0]`, with no extra term.
- R5: For same rank, read then write gives G = `baseGap[1]` + `extraGap[0]`, and write then read gives G = `baseGap[2]` + `extraGap[1]`.
- R6: For different ranks, the transitions give these gaps:
  - read then read: G = `baseGap[3]` + `extraGap[2]`
  - read then write: G = `baseGap[4]` + `extraGap[3]`
  - write then write: G = `baseGap[5]` + `extraGap[4]`
  - write then read: G = `baseGap[6]` + `extraGap[5]`
- R7: With every extra entry at 0, each gap equals its base entry alone.
- R8: When the candidate changes while waiting, its gap is compared against the cycles elapsed since the last accepted issue. If enough cycles have already elapsed, `issueOk` is 1 in the same cycle as the change.
- R9: Once `issueOk` is 1, it stays 1 until an accepted issue, provided the candidate and the gap settings are held.
- R10: The elapsed count saturates and never wraps, so `issueOk` stays 1 after an arbitrarily long idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueStb | input | 1 | Controller issues the candidate this cycle |
| candIsWrite | input | 1 | Candidate direction, 1 = write |
| candRank | input | RANK_W | Candidate rank |
| baseGap | input | 7*GAP_W | Base gap per transition kind, index k |
| extraGap | input | 6*GAP_W | Extra gap per kind 1..6, index k-1 |
| issueOk | output | 1 | Candidate may be issued this cycle |

## Verification
The bench builds the block with RANK_W=2 and GAP_W=3. Four ranks let the different-rank transitions run across several rank pairs. The three-bit settings give sums up to 11, which exercises the widened adder. The four-bit elapsed counter is small enough that a 40-cycle idle period drives it into saturation. Changing the extra settings at run time brings the zero-extra case into the same run.

// File: rtl/tgap_pkg.sv
package tgap_pkg;
  typedef enum logic [2:0] {
    K_SAME  = 3'd0,
    K_RW_SR = 3'd1,
    K_WR_SR = 3'd2,
    K_RR_DR = 3'd3,
    K_RW_DR = 3'd4,
    K_WW_DR = 3'd5,
    K_WR_DR = 3'd6
  } tgap_kind_t;

  localparam int NUM_KINDS = 7;
  localparam int NUM_EXTRA = NUM_KINDS - 1;

  typedef struct packed {
    logic restart;
    logic advance;
  } tgap_strb_t;
endpackage

// File: rtl/tgap_ctrl.sv
module tgap_ctrl
  import tgap_pkg::*;
#(
  parameter int RANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueStb,
  input  logic              candIsWrite,
  input  logic [RANK_W-1:0] candRank,
  input  logic              gapMet,
  output tgap_kind_t        kindSel,
  output tgap_strb_t        strb,
  output logic              issueOk
);
  logic              prevValid;
  logic              prevIsWrite;
  logic [RANK_W-1:0] prevRank;
  logic              accept;

  assign issueOk = !prevValid || gapMet;
  assign accept  = issueStb && issueOk;

  always_comb begin
    strb.restart = accept;
    strb.advance = !accept;
  end

  always_comb begin
    if (candRank == prevRank) begin
      if (prevIsWrite == candIsWrite) kindSel = K_SAME;
      else if (candIsWrite)           kindSel = K_RW_SR;
      else                            kindSel = K_WR_SR;
    end else begin
      case ({prevIsWrite, candIsWrite})
        2'b00:   kindSel = K_RR_DR;
        2'b01:   kindSel = K_RW_DR;
        2'b11:   kindSel = K_WW_DR;
        default: kindSel = K_WR_DR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid   <= 1'b0;
      prevIsWrite <= 1'b0;
      prevRank    <= '0;
    end else if (accept) begin
      prevValid   <= 1'b1;
      prevIsWrite <= candIsWrite;
      prevRank    <= candRank;
    end
  end

  AST_IGNORED_STB: assert property (@(posedge clk) disable iff (!rstN)
    (issueStb && !issueOk) |=> ($stable(prevIsWrite) && $stable(prevRank) && $stable(prevValid))); // R2
endmodule

// File: rtl/tgap_dpath.sv
module tgap_dpath
  import tgap_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  tgap_strb_t                      strb,
  input  tgap_kind_t                      kindSel,
  input  logic [NUM_KINDS-1:0][GAP_W-1:0] baseGap,
  input  logic [NUM_EXTRA-1:0][GAP_W-1:0] extraGap,
  output logic                            gapMet
);
  localparam int CNT_W = GAP_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] reqGap;
  logic [NUM_KINDS-1:0][CNT_W-1:0] kindGap;

  genvar k;
  generate
    for (k = 0; k < NUM_KINDS; k++) begin : g_kind
      if (k == 0) begin : g_plain
        assign kindGap[k] = {1'b0, baseGap[k]};
      end else begin : g_sum
        assign kindGap[k] = {1'b0, baseGap[k]} + {1'b0, extraGap[k-1]};
      end
    end
  endgenerate

  assign reqGap = kindGap[kindSel];
  assign gapMet = (elapsed >= reqGap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              elapsed <= '0;
    else if (strb.restart)                  elapsed <= '0;
    else if (strb.advance && elapsed != CNT_MAX) elapsed <= elapsed + 1'b1;
  end

  AST_GAP_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.restart) && reqGap != '0) |-> !gapMet); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.restart |=> (elapsed >= $past(elapsed))); // R10
endmodule

// File: rtl/tgap_top.sv
module tgap_top
  import tgap_pkg::*;
#(
  parameter int RANK_W = 2,
  parameter int GAP_W  = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            issueStb,
  input  logic                            candIsWrite,
  input  logic [RANK_W-1:0]               candRank,
  input  logic [NUM_KINDS-1:0][GAP_W-1:0] baseGap,
  input  logic [NUM_EXTRA-1:0][GAP_W-1:0] extraGap,
  output logic                            issueOk
);
  tgap_kind_t kindSel;
  tgap_strb_t strb;
  logic       gapMet;

  tgap_ctrl #(.RANK_W(RANK_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .issueStb(issueStb), .candIsWrite(candIsWrite),
    .candRank(candRank), .gapMet(gapMet), .kindSel(kindSel), .strb(strb),
    .issueOk(issueOk)
  );

  tgap_dpath #(.GAP_W(GAP_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .kindSel(kindSel),
    .baseGap(baseGap), .extraGap(extraGap), .gapMet(gapMet)
  );

  AST_OK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (issueOk && !issueStb) |=> (issueOk || !$stable(candIsWrite) || !$stable(candRank)
                                || !$stable(baseGap) || !$stable(extraGap))); // R9
endmodule

// File: tb/tgap_top_tb_top.sv
module tgap_top_tb_top;
  localparam int RANK_W = 2;
  localparam int GAP_W  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueStb = 1'b0;
  logic candIsWrite = 1'b0;
  logic [RANK_W-1:0] candRank = '0;
  logic [6:0][GAP_W-1:0] baseGap;
  logic [5:0][GAP_W-1:0] extraGap;
  logic issueOk;

  int cfgBase[7]  = '{1, 2, 3, 1, 2, 0, 4};
  int cfgExtra[6] = '{3, 1, 2, 0, 5, 7};

  int checks = 0;
  int failures = 0;
  string curTag = "R1";
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  bit mValid = 1'b0;
  bit mWrite = 1'b0;
  int mRank = 0;
  int mElapsed = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 7; i++) baseGap[i] = cfgBase[i][GAP_W-1:0];
    for (int i = 0; i < 6; i++) extraGap[i] = cfgExtra[i][GAP_W-1:0];
  end

  tgap_top #(.RANK_W(RANK_W), .GAP_W(GAP_W)) dut_i (
    .clk(clk), .rstN(rstN), .issueStb(issueStb), .candIsWrite(candIsWrite),
    .candRank(candRank), .baseGap(baseGap), .extraGap(extraGap), .issueOk(issueOk)
  );

  function automatic int reqGap(bit w, int r);
    if (r == mRank) begin
      if (w == mWrite) return cfgBase[0];
      return w ? cfgBase[1] + cfgExtra[0] : cfgBase[2] + cfgExtra[1];
    end
    if (!mWrite && !w) return cfgBase[3] + cfgExtra[2];
    if (!mWrite && w)  return cfgBase[4] + cfgExtra[3];
    if (mWrite && w)   return cfgBase[5] + cfgExtra[4];
    return cfgBase[6] + cfgExtra[5];
  endfunction

  function automatic bit modelOk();
    return !mValid || (mElapsed >= reqGap(candIsWrite, int'(candRank)));
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      if (issueStb && modelOk()) begin
        mValid = 1'b1; mWrite = candIsWrite; mRank = int'(candRank); mElapsed = 0;
      end else begin
        mElapsed = mElapsed + 1;
      end
    end
  end

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s issueOk actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmpOn) check(issueOk, modelOk(), curTag);

  task automatic drive(bit s, bit w, int r);
    @(posedge clk); #2;
    issueStb = s; candIsWrite = w; candRank = r[RANK_W-1:0];
  endtask

  task automatic issueThen(bit w, int r, bit nw, int nr);
    drive(1'b1, w, r);
    drive(1'b0, nw, nr);
  endtask

  task automatic measure(int exp, string tag);
    int n = 0;
    curTag = tag;
    forever begin
      @(negedge clk); #1;
      if (issueOk || n > 100) break;
      n++;
    end
    checks++;
    if (n != exp) begin
      failures++;
      $display("FAIL %s gap actual=%0d expected=%0d", tag, n, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1: free to issue after reset, any candidate
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1; check(issueOk, 1'b1, "R1");
      @(posedge clk); #2; candIsWrite = i[0]; candRank = i[RANK_W-1:0];
    end
    cmpOn = 1'b1;
    @(posedge clk); #2; candIsWrite = 1'b0; candRank = '0;
    issueThen(0, 0, 0, 0); measure(1, "R3 R4");
    issueThen(0, 0, 1, 0); measure(5, "R3 R5");
    issueThen(1, 0, 1, 0); measure(1, "R4");
    issueThen(1, 0, 0, 0); measure(4, "R5");
    issueThen(0, 0, 0, 1); measure(3, "R6");
    issueThen(0, 1, 1, 2); measure(2, "R6");
    issueThen(1, 2, 1, 3); measure(5, "R6");
    issueThen(1, 3, 0, 0); measure(11, "R6");
    // R2: strobe while blocked is ignored
    curTag = "R2";
    drive(1'b1, 0, 0);
    drive(1'b1, 1, 0);
    drive(1'b0, 1, 0);
    measure(4, "R2");
    // R8: candidate switch after elapsed cycles
    curTag = "R8";
    issueThen(1, 0, 1, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1; check(issueOk, 1'b0, "R8");
    end
    drive(1'b0, 1, 0);
    @(negedge clk); #1; check(issueOk, 1'b1, "R8");
    // R7: zero extras leave the base gap
    for (int i = 0; i < 6; i++) cfgExtra[i] = 0;
    issueThen(1, 0, 0, 0); measure(3, "R7");
    issueThen(0, 0, 1, 0); measure(2, "R7");
    issueThen(1, 0, 0, 3); measure(4, "R7 R6");
    // R10: long idle, counter must not wrap
    curTag = "R10 R9";
    repeat (40) @(posedge clk);
    @(negedge clk); #1; check(issueOk, 1'b1, "R10");
    drive(1'b0, 1, 3);
    @(negedge clk); #1; check(issueOk, 1'b1, "R10");
    cmpOn = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule